// File: doc/BRIEF.md
# Noise-Shaping Quantizer Digital Back-End

This block is the digital half of an oversampled quantizer inside a sigma-delta modulator. Two comparators produce a three-valued decision (-1, 0, +1) on every cycle of a fast clock. The fast clock runs at four times the main loop rate. The block sums the most recent three decisions with a multiplier-free boxcar filter. It keeps one filtered value per slow period and drops the rest. That value is then added into a saturating integrator with no extra delay. The integrator undoes the differentiation that the analog front end applies ahead of the comparators.

The integrator level is limited to nine values. The block presents this level in three forms: as a signed word, as an eight-element thermometer word for the element-shuffling feedback converter, and as a copy of the level one slow sample earlier. The analog side uses that delayed copy to form the error-feedback difference. An internal phase counter generates the slow-rate strobe. The block also drives the strobe out, so neighbouring logic can align to the slow samples.

Top module: `mrq_backend`

## Requirements
- R1: While `rst_n` is low, `slow_stb` is 0, `dec_val`, `lvl` and `lvl_prev` are 0, and `therm` is 8'b0000_1111.
- R2: After reset is released, `slow_stb` is high during every fourth fast cycle: fast cycles 3, 7, 11 and so on, counting from 0 at the first cycle after release. It is low during all other cycles.
- R3: The comparator pair decodes as follows ({`cmp_hi`,`cmp_lo`}): 2'b11 is +1, 2'b01 is 0 and 2'b00 is -1. The inconsistent pattern 2'b10 is read as 0.
- R4: At the clock edge that ends a strobe cycle, `dec_val` takes the sum of the decoded sample of that cycle and the samples of the two cycles before it. The sample taken in the first cycle of each slow period therefore has no effect.
- R5: `dec_val` keeps its value at every edge that does not end a strobe cycle.
- R6: At the edge that ends a strobe cycle, `lvl` becomes the previous `lvl` plus the new filter sum. The new value is visible in the cycle after that edge, together with the matching `dec_val`.
- R7: `lvl` is saturated to the range -4..+4. A sum above +4 gives +4, and a sum below -4 gives -4.
- R8: `therm` has its lowest `lvl`+4 bits set to 1 and all higher bits cleared to 0.
- R9: At the edge that ends a strobe cycle, `lvl_prev` takes the value that `lvl` held just before that edge.
- R10: `lvl` and `lvl_prev` keep their values at every edge that does not end a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the loop rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hi | input | 1 | Upper comparator decision |
| cmp_lo | input | 1 | Lower comparator decision |
| slow_stb | output | 1 | High in the last fast cycle of each slow period |
| dec_val | output | 3 | Decimated filter sum, signed -3..+3 |
| lvl | output | 4 | Integrated and clipped level, signed -4..+4 |
| lvl_prev | output | 4 | Level one slow sample earlier |
| therm | output | 8 | Thermometer code of `lvl`+4 |

## Verification
The hardest states to reach from the ports are the two saturation limits, and the case where only the discarded first sample of a slow period carries signal. Random three-valued streams tend to drift around zero. Directed runs therefore hold the comparators at +1 and then at -1 for several slow periods, which pins the level at each rail. Another run places a nonzero decision in the first fast cycle of a period and zero in the others. The bench keeps its own count of the phase, so it can align each of these patterns to the slow period.

// File: rtl/mrq_pkg.sv
package mrq_pkg;
  // comparator pair encodings {hi, lo}
  localparam logic [1:0] CMP_NEG  = 2'b00;
  localparam logic [1:0] CMP_ZERO = 2'b01;
  localparam logic [1:0] CMP_POS  = 2'b11;
  localparam logic [1:0] CMP_BAD  = 2'b10;

  typedef logic signed [1:0] tri_smp_t;
endpackage

// File: rtl/mrq_pacer.sv
module mrq_pacer #(
  parameter int RATE = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic stb
);
  localparam int PW = (RATE > 2) ? $clog2(RATE) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATE - 1);

  logic [PW-1:0] phase_q, phase_d;

  always_comb begin
    if (phase_q == LAST) phase_d = '0;
    else                 phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign stb = (phase_q == LAST);

  // R2
  stb_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
endmodule

// File: rtl/mrq_boxcar.sv
module mrq_boxcar
  import mrq_pkg::*;
#(
  parameter int TAPS = 3,
  parameter int SW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmp_hi,
  input  logic                 cmp_lo,
  output logic signed [SW-1:0] sum
);
  localparam int HL = TAPS - 1;

  tri_smp_t smp;
  tri_smp_t hist_q [HL];
  tri_smp_t hist_d [HL];

  // decode comparator pair (R3)
  always_comb begin
    unique case ({cmp_hi, cmp_lo})
      CMP_POS:  smp = 2'sd1;
      CMP_NEG:  smp = -2'sd1;
      default:  smp = 2'sd0;
    endcase
  end

  generate
    for (genvar i = 0; i < HL; i++) begin : g_tap
      if (i == 0) begin : g_first
        always_comb hist_d[i] = smp;
      end else begin : g_rest
        always_comb hist_d[i] = hist_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q[i] <= '0;
        else        hist_q[i] <= hist_d[i];
      end
    end
  endgenerate

  always_comb begin
    logic signed [SW-1:0] acc;
    acc = {{(SW-2){smp[1]}}, smp};
    for (int i = 0; i < HL; i++)
      acc = acc + {{(SW-2){hist_q[i][1]}}, hist_q[i]};
    sum = acc;
  end

  // R4
  sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum <= SW'(TAPS)) && (sum >= -SW'(TAPS)));
endmodule

// File: rtl/mrq_integ.sv
module mrq_integ #(
  parameter int SW   = 3,
  parameter int AW   = 4,
  parameter int HALF = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb,
  input  logic signed [SW-1:0] sum,
  output logic signed [SW-1:0] dec_q,
  output logic signed [AW-1:0] lvl_q,
  output logic signed [AW-1:0] prev_q
);
  localparam int WW = ((AW > SW) ? AW : SW) + 1;
  localparam logic signed [WW-1:0] HI = WW'(HALF);
  localparam logic signed [WW-1:0] LO = -WW'(HALF);

  logic signed [SW-1:0] dec_d;
  logic signed [AW-1:0] lvl_d, prev_d;
  logic signed [WW-1:0] raw;

  always_comb begin
    raw = WW'(lvl_q) + WW'(sum);
    dec_d  = dec_q;
    lvl_d  = lvl_q;
    prev_d = prev_q;
    if (stb) begin
      dec_d  = sum;
      prev_d = lvl_q;
      if (raw > HI)      lvl_d = AW'(HI);
      else if (raw < LO) lvl_d = AW'(LO);
      else               lvl_d = AW'(raw);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else if (stb) begin
      dec_q  <= dec_d;
      lvl_q  <= lvl_d;
      prev_q <= prev_d;
    end
  end

  // R7
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (WW'(lvl_q) <= HI) && (WW'(lvl_q) >= LO));
  // R10
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> ($stable(lvl_q) && $stable(prev_q)));
  // R5
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(dec_q));
  // R9
  prev_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (prev_q == $past(lvl_q)));
  // R6
  dec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (dec_q == $past(sum)));
endmodule

// File: rtl/mrq_therm.sv
module mrq_therm #(
  parameter int AW   = 4,
  parameter int HALF = 4
) (
  input  logic signed [AW-1:0]     lvl,
  output logic        [2*HALF-1:0] therm
);
  localparam int TW = 2 * HALF;
  localparam int WW = AW + 1;

  logic signed [WW-1:0] weight;
  assign weight = WW'(lvl) + WW'(HALF);

  generate
    for (genvar i = 0; i < TW; i++) begin : g_bit
      assign therm[i] = (weight > WW'(i));
    end
  endgenerate

  // R8
  therm_weight_chk: assert final (($countones(therm) == int'(weight)) ||
                                  (weight < 0) || (weight > WW'(TW)));
endmodule

// File: rtl/mrq_backend.sv
module mrq_backend #(
  parameter int RATE = 4,
  parameter int HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmp_hi,
  input  logic        cmp_lo,
  output logic        slow_stb,
  output logic [2:0]  dec_val,
  output logic [3:0]  lvl,
  output logic [3:0]  lvl_prev,
  output logic [7:0]  therm
);
  localparam int TAPS = RATE - 1;
  localparam int SW   = $clog2(TAPS + 1) + 1;
  localparam int AW   = $clog2(HALF + 1) + 1;
  localparam int TW   = 2 * HALF;

  logic                 stb;
  logic signed [SW-1:0] fir_sum, dec_q;
  logic signed [AW-1:0] lvl_q, prev_q;
  logic        [TW-1:0] therm_w;

  mrq_pacer #(.RATE(RATE)) u_pacer (
    .clk(clk), .rst_n(rst_n), .stb(stb)
  );

  mrq_boxcar #(.TAPS(TAPS), .SW(SW)) u_boxcar (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .sum(fir_sum)
  );

  mrq_integ #(.SW(SW), .AW(AW), .HALF(HALF)) u_integ (
    .clk(clk), .rst_n(rst_n), .stb(stb), .sum(fir_sum),
    .dec_q(dec_q), .lvl_q(lvl_q), .prev_q(prev_q)
  );

  mrq_therm #(.AW(AW), .HALF(HALF)) u_therm (
    .lvl(lvl_q), .therm(therm_w)
  );

  assign slow_stb = stb;
  assign dec_val  = 3'(dec_q);
  assign lvl      = 4'(lvl_q);
  assign lvl_prev = 4'(prev_q);
  assign therm    = 8'(therm_w);
endmodule

// File: tb/mrq_backend_tb.sv
module mrq_backend_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic cmp_hi, cmp_lo;
  logic slow_stb;
  logic [2:0] dec_val;
  logic [3:0] lvl, lvl_prev;
  logic [7:0] therm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_phase, m_h1, m_h2, m_dec, m_lvl, m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  mrq_backend u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .slow_stb(slow_stb), .dec_val(dec_val), .lvl(lvl),
    .lvl_prev(lvl_prev), .therm(therm)
  );

  function automatic int decode(bit hi, bit lo);
    if (hi && lo) return 1;
    if (!hi && !lo) return -1;
    return 0;
  endfunction

  function automatic int clip(int v);
    if (v > 4) return 4;
    if (v < -4) return -4;
    return v;
  endfunction

  function automatic int therm_of(int v);
    return (1 << (v + 4)) - 1;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R2 strobe", int'(slow_stb), (m_phase == 3) ? 1 : 0);
    check("R4 R5 dec_val", int'($signed(dec_val)), m_dec);
    check("R6 R10 lvl", int'($signed(lvl)), m_lvl);
    check("R9 lvl_prev", int'($signed(lvl_prev)), m_prev);
    check("R8 therm", int'(therm), therm_of(m_lvl));
  endtask

  task automatic step(bit hi, bit lo);
    int d;
    cmp_hi = hi;
    cmp_lo = lo;
    d = decode(hi, lo);
    @(posedge clk);
    if (m_phase == 3) begin
      m_dec  = d + m_h1 + m_h2;
      m_prev = m_lvl;
      m_lvl  = clip(m_lvl + m_dec);
    end
    m_h2 = m_h1;
    m_h1 = d;
    m_phase = (m_phase + 1) % 4;
    @(negedge clk);
    check_all();
  endtask

  task automatic step_val(int v);
    if (v > 0)      step(1'b1, 1'b1);
    else if (v < 0) step(1'b0, 1'b0);
    else            step(1'b0, 1'b1);
  endtask

  task automatic align();
    while (m_phase != 0) step_val(0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'h5eed_0a17);
    rst_n = 1'b0;
    cmp_hi = 1'b0;
    cmp_lo = 1'b0;
    m_phase = 0; m_h1 = 0; m_h2 = 0; m_dec = 0; m_lvl = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 strobe", int'(slow_stb), 0);
    check("R1 dec_val", int'(dec_val), 0);
    check("R1 lvl", int'(lvl), 0);
    check("R1 lvl_prev", int'(lvl_prev), 0);
    check("R1 therm", int'(therm), 8'h0F);
    rst_n = 1'b1;

    // R7 upper rail: long run of +1
    repeat (16) step_val(1);
    check("R7 upper rail", int'($signed(lvl)), 4);
    // R7 lower rail
    repeat (20) step_val(-1);
    check("R7 lower rail", int'($signed(lvl)), -4);
    check("R8 empty therm", int'(therm), 0);

    // R4: only the first sample of the period is nonzero
    align();
    step_val(1); step_val(0); step_val(0); step_val(0);
    check("R4 first sample dropped", int'($signed(dec_val)), 0);
    align();
    step_val(-1); step_val(1); step_val(1); step_val(1);
    check("R4 three newest summed", int'($signed(dec_val)), 3);

    // R3: inconsistent comparator pattern reads as zero
    align();
    repeat (4) step(1'b1, 1'b0);
    check("R3 bad code zero", int'($signed(dec_val)), 0);
    align();
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1); step(1'b1, 1'b0);
    check("R3 mixed bad code", int'($signed(dec_val)), 1);

    // random three-valued streams, some biased
    for (int blk = 0; blk < 6; blk++) begin
      for (int i = 0; i < 200; i++) begin
        int v;
        r = $urandom % 100;
        if (blk % 3 == 1)      v = (r < 60) ? 1 : ((r < 80) ? 0 : -1);
        else if (blk % 3 == 2) v = (r < 60) ? -1 : ((r < 80) ? 0 : 1);
        else                   v = int'(r % 3) - 1;
        if ((r % 17) == 0) step(1'b1, 1'b0);
        else               step_val(v);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule